// File: doc/BRIEF.md
# SAR Conversion Start Sequencer

This block times one conversion of a successive-approximation converter. It runs on a system clock in which every edge stands for one half period of the converter's master clock: a phase register toggles on each edge and is brought out as `mclk_hi`. When `mclk_hi` is 1 before an edge, that edge is a falling master-clock edge; when it is 0, that edge is a rising one. A conversion is requested either by a rising level on `conv_pin` or by a control write (`ctl_wr` high with `ctl_start` high) that sets the software start bit.

A request moves the sequencer from IDLE (tracking) to ARMED. In ARMED, `hold` is high and the analog code is frozen. At the next falling master edge the sequencer enters CONV and raises `busy`. The length of CONV depends on setup. If the request was already held at the rising master edge just before that falling edge, CONV lasts FAST_HALVES half periods (16.5 master periods by default). Otherwise it lasts SLOW_HALVES (17.5 periods). When CONV ends, `busy` falls, `data_valid` pulses for one cycle, the formatted result is loaded, and the software start bit clears. The sequencer then spends ACQ_HALVES half periods in ACQ (tracking) before it returns to IDLE. Requests that arrive outside IDLE are dropped and latch `start_err`.

Transitions: IDLE→ARMED on an accepted request; ARMED→CONV on a falling master edge; CONV→ACQ when the half-period count runs out; ACQ→IDLE when the acquisition count runs out. A behavioural model outside the block drives the 12 result bits on `adc_code`.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `hold`, `busy`, `data_valid`, `sw_start_bit`, `start_err` and `result` are all 0, and `mclk_hi` is 0.
- R2: In IDLE, a 0→1 change of `conv_pin`, or a cycle with `ctl_wr`=1 and `ctl_start`=1, raises `hold` at that edge. A write with `ctl_start`=0 starts nothing.
- R3: `busy` rises only on a falling master edge (an edge where `mclk_hi` was 1) while `hold` is already high.
- R4: `busy` stays high for FAST_HALVES cycles (33) if the request was accepted on a falling master edge, so that it was held at the following rising edge. It stays high for SLOW_HALVES cycles (35) if the request was accepted on a rising master edge.
- R5: `data_valid` is high for exactly the one cycle right after the edge on which `busy` falls.
- R6: A software-started conversion shows `sw_start_bit`=1 while `busy` is high, and the bit is 0 from the edge on which `busy` falls.
- R7: After `busy` falls, `hold` stays low for at least ACQ_HALVES cycles (4), and no request is accepted during that window.
- R8: With `bipolar_mode`=0 the result is the code unchanged (straight binary). With `bipolar_mode`=1 the result is the code with bit 11 inverted (twos complement about mid-scale). The mode is sampled on the edge where `busy` falls.
- R9: A request arriving while the sequencer is in ARMED, CONV or ACQ does not change the running conversion. It sets `start_err`, which stays at 1 until reset.
- R10: `result` is the code captured on the edge where `hold` rose. It stays unchanged in every cycle except the one in which `data_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one edge per master half period |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_pin | input | 1 | Hardware start request, active on a rising level |
| ctl_wr | input | 1 | Control write strobe |
| ctl_start | input | 1 | Software start bit carried by the control write |
| bipolar_mode | input | 1 | 0 straight binary, 1 twos complement |
| adc_code | input | RES_W | Code from the behavioural converter model |
| mclk_hi | output | 1 | Master clock phase; 1 means the next edge is falling |
| hold | output | 1 | Track/hold in hold (ARMED or CONV) |
| busy | output | 1 | Conversion in progress |
| data_valid | output | 1 | One-cycle pulse when a result is loaded |
| result | output | RES_W | Formatted conversion result |
| sw_start_bit | output | 1 | Software start bit |
| start_err | output | 1 | Sticky flag for a dropped request |

## Verification
The bench builds the block with its default parameters: FAST_HALVES=33, SLOW_HALVES=35, ACQ_HALVES=4 and RES_W=12. At these values both conversion lengths and the full acquisition window fit in a few dozen cycles, so every conversion can be timed edge by edge. The bench aligns each request to a chosen master phase, which reaches both setup outcomes. Random codes, modes and start sources are mixed with directed end-of-scale codes. Requests are also placed inside CONV and inside ACQ to drive the dropped-start path.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_CONV  = 2'd2,
        SEQ_ACQ   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_pin,
    input  logic ctl_wr,
    input  logic ctl_start,
    input  logic accept,
    input  logic clear_sw,
    output logic req,
    output logic sw_bit
);
    logic pin_q;
    logic req_pin;
    logic req_sw;

    assign req_pin = conv_pin & ~pin_q;
    assign req_sw  = ctl_wr & ctl_start;
    assign req     = req_pin | req_sw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            sw_bit <= 1'b0;
        end else begin
            pin_q <= conv_pin;
            if (clear_sw)
                sw_bit <= 1'b0;
            else if (accept && req_sw)
                sw_bit <= 1'b1;
        end
    end
endmodule

// File: rtl/sar_half_counter.sv
module sar_half_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             update,
    input  logic             bipolar,
    input  logic [RES_W-1:0] code_in,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] held_q;
    logic [RES_W-1:0] formatted;

    always_comb begin
        formatted = held_q;
        if (bipolar)
            formatted[RES_W-1] = ~held_q[RES_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            result <= '0;
        end else begin
            if (capture)
                held_q <= code_in;
            if (update)
                result <= formatted;
        end
    end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_W       = 12,
    parameter int FAST_HALVES = 33,
    parameter int SLOW_HALVES = 35,
    parameter int ACQ_HALVES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_pin,
    input  logic             ctl_wr,
    input  logic             ctl_start,
    input  logic             bipolar_mode,
    input  logic [RES_W-1:0] adc_code,
    output logic             mclk_hi,
    output logic             hold,
    output logic             busy,
    output logic             data_valid,
    output logic [RES_W-1:0] result,
    output logic             sw_start_bit,
    output logic             start_err
);
    import sar_seq_pkg::*;

    localparam int MAX_HALVES = (SLOW_HALVES > ACQ_HALVES) ? SLOW_HALVES : ACQ_HALVES;
    localparam int CNT_W      = $clog2(MAX_HALVES + 1);
    localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_HALVES - 1);
    localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_HALVES - 1);
    localparam logic [CNT_W-1:0] ACQ_LD  = CNT_W'(ACQ_HALVES - 1);

    seq_state_t       state_q, state_d;
    logic             ph_q;
    logic             seen_rise_q;
    logic             valid_q;
    logic             err_q;
    logic             req;
    logic             accept;
    logic             cnt_zero;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             conv_done;

    sar_start_detect u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_pin  (conv_pin),
        .ctl_wr    (ctl_wr),
        .ctl_start (ctl_start),
        .accept    (accept),
        .clear_sw  (conv_done),
        .req       (req),
        .sw_bit    (sw_start_bit)
    );

    sar_half_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sar_result_fmt #(.RES_W(RES_W)) u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .update  (conv_done),
        .bipolar (bipolar_mode),
        .code_in (adc_code),
        .result  (result)
    );

    assign accept    = (state_q == SEQ_IDLE) && req;
    assign conv_done = (state_q == SEQ_CONV) && cnt_zero;

    // next state and counter loading
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (req)
                    state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (ph_q) begin
                    state_d  = SEQ_CONV;
                    cnt_load = 1'b1;
                    cnt_val  = seen_rise_q ? FAST_LD : SLOW_LD;
                end
            end
            SEQ_CONV: begin
                if (cnt_zero) begin
                    state_d  = SEQ_ACQ;
                    cnt_load = 1'b1;
                    cnt_val  = ACQ_LD;
                end
            end
            SEQ_ACQ: begin
                if (cnt_zero)
                    state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            ph_q        <= 1'b0;
            seen_rise_q <= 1'b0;
            valid_q     <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ~ph_q;
            valid_q <= conv_done;
            if (req && state_q != SEQ_IDLE)
                err_q <= 1'b1;
            if (accept)
                seen_rise_q <= 1'b0;
            else if (state_q == SEQ_ARMED && !ph_q)
                seen_rise_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        hold = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  hold = 1'b0;
            SEQ_ARMED: hold = 1'b1;
            SEQ_CONV: begin
                hold = 1'b1;
                busy = 1'b1;
            end
            SEQ_ACQ:   hold = 1'b0;
            default:   hold = 1'b0;
        endcase
    end

    assign mclk_hi    = ph_q;
    assign data_valid = valid_q;
    assign start_err  = err_q;

    // checker counters: busy run length and cycles since busy fell
    logic [CNT_W-1:0] chk_busy_len;
    logic [CNT_W-1:0] chk_gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_busy_len <= '0;
            chk_gap      <= CNT_W'(ACQ_HALVES);
        end else begin
            if (busy)
                chk_busy_len <= chk_busy_len + 1'b1;
            else
                chk_busy_len <= '0;
            if (busy)
                chk_gap <= '0;
            else if (chk_gap < CNT_W'(ACQ_HALVES))
                chk_gap <= chk_gap + 1'b1;
        end
    end

    assert_busy_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(hold) && $past(mclk_hi)));

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(chk_busy_len) == CNT_W'(FAST_HALVES - 1) ||
                         $past(chk_busy_len) == CNT_W'(SLOW_HALVES - 1)));

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $fell(busy));

    assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !sw_start_bit);

    assert_acq_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> ($past(chk_gap) >= CNT_W'(ACQ_HALVES)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |=> start_err);

    assert_result_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> $stable(result));
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
    localparam int RES_W = 12;
    localparam int FAST  = 33;
    localparam int SLOW  = 35;
    localparam int ACQ   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             conv_pin = 1'b0;
    logic             ctl_wr = 1'b0;
    logic             ctl_start = 1'b0;
    logic             bipolar_mode = 1'b0;
    logic [RES_W-1:0] adc_code = '0;
    logic             mclk_hi, hold, busy, data_valid, sw_start_bit, start_err;
    logic [RES_W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sar_conv_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_pin     (conv_pin),
        .ctl_wr       (ctl_wr),
        .ctl_start    (ctl_start),
        .bipolar_mode (bipolar_mode),
        .adc_code     (adc_code),
        .mclk_hi      (mclk_hi),
        .hold         (hold),
        .busy         (busy),
        .data_valid   (data_valid),
        .result       (result),
        .sw_start_bit (sw_start_bit),
        .start_err    (start_err)
    );

    function automatic logic [RES_W-1:0] exp_result(logic [RES_W-1:0] code, logic bip);
        return bip ? (code ^ (12'h1 << (RES_W - 1))) : code;
    endfunction

    function automatic int exp_len(logic fast);
        return fast ? FAST : SLOW;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one conversion; want_fast picks the phase the request lands on
    task automatic run_conv(input bit use_sw, input bit want_fast,
                            input logic [RES_W-1:0] code, input bit bip, input bit poke);
        int n;
        logic [RES_W-1:0] prev;
        @(negedge clk);
        while (mclk_hi != want_fast) @(negedge clk);
        adc_code     = code;
        bipolar_mode = bip;
        if (use_sw) begin ctl_wr = 1'b1; ctl_start = 1'b1; end
        else conv_pin = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_start = 1'b0; conv_pin = 1'b0;
        adc_code = ~code;
        chk(hold == 1'b1 && busy == 1'b0, "R2 hold after request", {hold, busy}, 2'b10);
        if (want_fast) begin
            @(negedge clk);
            chk(busy == 1'b0, "R3 busy waits for falling edge", busy, 0);
        end
        @(negedge clk);
        chk(busy == 1'b1, "R3 busy at falling edge", busy, 1);
        if (use_sw) chk(sw_start_bit == 1'b1, "R6 sw bit while busy", sw_start_bit, 1);
        n = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            conv_pin = (poke && n == 5);
            if (!busy) break;
            n++;
        end
        conv_pin = 1'b0;
        chk(n == exp_len(want_fast), "R4 busy length", n, exp_len(want_fast));
        chk(data_valid == 1'b1, "R5 valid on busy fall", data_valid, 1);
        chk(result == exp_result(code, bip), "R8 R10 result", result, exp_result(code, bip));
        chk(sw_start_bit == 1'b0, "R6 sw bit cleared", sw_start_bit, 0);
        if (poke) chk(start_err == 1'b1, "R9 err on request in CONV", start_err, 1);
        prev = result;
        @(negedge clk);
        chk(data_valid == 1'b0, "R5 valid one cycle", data_valid, 0);
        for (int k = 0; k < ACQ + 1; k++) @(negedge clk);
        chk(result == prev, "R10 result held", result, prev);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk({hold, busy, data_valid, sw_start_bit, start_err, mclk_hi} == 6'b0 && result == '0,
            "R1 reset state", {hold, busy, data_valid, sw_start_bit, start_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: write without the start bit starts nothing
        ctl_wr = 1'b1; ctl_start = 1'b0;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk(hold == 1'b0, "R2 write without start bit", hold, 0);
        @(negedge clk);
        chk(hold == 1'b0 && start_err == 1'b0, "R2 still idle", {hold, start_err}, 0);

        // directed corner codes, both phases and both modes
        run_conv(0, 1, 12'h000, 0, 0);
        run_conv(0, 0, 12'hFFF, 0, 0);
        run_conv(1, 1, 12'h800, 1, 0);
        run_conv(1, 0, 12'h7FF, 1, 0);
        run_conv(0, 1, 12'h000, 1, 0);
        chk(start_err == 1'b0, "R9 no err on clean starts", start_err, 0);

        // random conversions
        for (int i = 0; i < 24; i++) begin
            run_conv($urandom_range(0, 1), $urandom_range(0, 1),
                     RES_W'($urandom), $urandom_range(0, 1), 1'b0);
        end

        // R7: request right after busy falls is dropped
        @(negedge clk);
        while (mclk_hi != 1'b1) @(negedge clk);
        conv_pin = 1'b1;
        @(negedge clk);
        conv_pin = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (data_valid) break;
        end
        conv_pin = 1'b1;
        @(negedge clk);
        conv_pin = 1'b0;
        for (int k = 0; k < ACQ + 2; k++) begin
            chk(hold == 1'b0, "R7 no hold in acquisition", hold, 0);
            @(negedge clk);
        end
        chk(start_err == 1'b1, "R7 R9 dropped request flagged", start_err, 1);

        // R9: request during CONV leaves the conversion untouched
        run_conv(0, 0, 12'h5A3, 0, 1);
        run_conv(1, 1, 12'h1C7, 1, 1);
        chk(start_err == 1'b1, "R9 err stays set", start_err, 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule